// File: doc/BRIEF.md
# Guarded SPI Host Transaction Engine

This block is an SPI master for slow peripherals that cannot keep up with back-to-back byte shifting. A single request supplies an opcode byte and a count of data bytes. The engine lowers the chip select and sends the opcode followed by the data bytes, MSB first, in SPI mode 0. It captures one MISO byte for every byte it shifts out. Write data is pulled from a stream, one byte per take pulse. Each received byte is offered on a valid strobe. A one-cycle done pulse closes the transaction.

Between the chip-select edges and the clocking, the engine holds fixed waiting intervals:
- a lead time from select falling to the first clock rise;
- a low gap between consecutive bytes;
- a trail time from the last clock fall to select rising;
- a rest time after select rises, before another request can be accepted.

All intervals and the clock half period are parameters counted in system clock cycles. A host sizes them from its own clock frequency. For example, at 16 MHz the defaults give a 125 kHz serial clock and intervals of 65, 40, 100 and 50 microseconds.

Top module: `spi_guard_host`

## Requirements
- R1: While reset is held, `nss` is 1, `sck` is 0, `reqReady` is 1, and `rdValid`, `wrTake` and `done` are 0.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. At that edge `nss` falls and `reqReady` drops to 0.
- R3: The first rising edge of `sck` comes exactly LEAD_CYC cycles after `nss` falls.
- R4: Inside a byte, `sck` is high for HALF_CYC cycles and low for HALF_CYC cycles. `sck` is low whenever `nss` is high (mode 0).
- R5: The engine shifts out the opcode first and then `reqCount` data bytes, each MSB first. For each data byte it pulses `wrTake` for one cycle, and `wrData` is taken at the clock edge that ends that cycle.
- R6: MISO is sampled on each rising edge of `sck`. After the 8th sample of every byte, including the opcode byte, `rdValid` pulses once with the byte on `rdData`, first-sampled bit as bit 7. A transaction therefore gives `reqCount`+1 read bytes.
- R7: Between the last fall of one byte and the first rise of the next byte, `sck` stays low for exactly GAP_CYC cycles.
- R8: `nss` rises exactly TRAIL_CYC cycles after the last falling edge of `sck`.
- R9: `done` is a one-cycle pulse that is high in the cycle ending REST_CYC cycles after `nss` rose. `reqReady` returns to 1 at that edge.
- R10: A `reqCount` of 0 sends only the opcode byte, produces no `wrTake` pulse and gives exactly one read byte.
- R11: A request presented while `reqReady` is 0 is ignored. It starts no transaction and does not change the bytes being sent.
- R12: `mosi` changes only while `sck` is low. It never changes while `sck` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle; a request is accepted at this edge |
| reqOpcode | input | 8 | Opcode byte, sent first |
| reqCount | input | CNT_W | Number of data bytes after the opcode |
| wrData | input | 8 | Next data byte to send |
| wrTake | output | 1 | `wrData` is taken at the end of this cycle |
| rdValid | output | 1 | `rdData` holds a received byte |
| rdData | output | 8 | Received MISO byte |
| done | output | 1 | Transaction finished, including the rest time |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss | output | 1 | Chip select, active low |

## Verification
The bench uses several transaction shapes:
- **Opcode only.** This exposes any off-by-one in the byte count.
- **One and three data bytes.** These use asymmetric values such as 0x80 and 0x01, which separate MSB-first from LSB-first order.
- **Twelve-byte burst.** This cycles the inter-byte gap many times.
- **Requests spammed while busy.** These show whether a busy request leaks into the stream.

The modelled peripheral returns patterns such as 0x5A, 0xFF and 0x00. A slip of one sampling edge shows up as a wrong read byte.

For every transaction, the bench measures every interval in cycles:
- lead time;
- high and low phases;
- inter-byte gap;
- trail time;
- rest time.

It compares each measurement exactly, so both too-short and too-long intervals are caught.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

  // Strobes from the sequencer to the shifter, at most one edge action per cycle
  typedef struct packed {
    logic start;     // select low, load opcode
    logic rise;      // sck high, sample miso
    logic fall;      // sck low, advance mosi
    logic loadNext;  // with fall: load a fresh data byte
    logic relNss;    // select high
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HI, ST_LO, ST_GAP, ST_TRAIL, ST_REST
  } seqState_t;

endpackage

// File: rtl/spi_guard_ctrl.sv
module spi_guard_ctrl
  import spi_guard_pkg::*;
#(
  parameter int HALF_CYC  = 64,
  parameter int LEAD_CYC  = 1040,
  parameter int GAP_CYC   = 640,
  parameter int TRAIL_CYC = 1600,
  parameter int REST_CYC  = 800,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             lastBit,
  output dpStrobe_t        stb,
  output logic             reqReady,
  output logic             wrTake,
  output logic             rdValid,
  output logic             done
);

  localparam int M1   = (HALF_CYC > LEAD_CYC) ? HALF_CYC : LEAD_CYC;
  localparam int M2   = (GAP_CYC > TRAIL_CYC) ? GAP_CYC : TRAIL_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > REST_CYC) ? M3 : REST_CYC;
  localparam int TW   = $clog2(MAXT + 1);

  seqState_t        state, stateNxt;
  logic [TW-1:0]    timer, timerNxt;
  logic [CNT_W-1:0] bytesLeft, bytesLeftNxt;
  logic             expired;

  assign expired  = (timer == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNxt     = state;
    timerNxt     = expired ? timer : timer - TW'(1);
    bytesLeftNxt = bytesLeft;
    stb          = '0;
    wrTake       = 1'b0;
    rdValid      = 1'b0;
    done         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.start    = 1'b1;
          bytesLeftNxt = reqCount;
          timerNxt     = TW'(LEAD_CYC - 1);
          stateNxt     = ST_LEAD;
        end
      end
      ST_LEAD, ST_LO, ST_GAP: begin
        if (expired) begin
          stb.rise = 1'b1;
          timerNxt = TW'(HALF_CYC - 1);
          stateNxt = ST_HI;
        end
      end
      ST_HI: begin
        if (expired) begin
          stb.fall = 1'b1;
          if (!lastBit) begin
            timerNxt = TW'(HALF_CYC - 1);
            stateNxt = ST_LO;
          end else begin
            rdValid = 1'b1;
            if (bytesLeft != '0) begin
              stb.loadNext = 1'b1;
              wrTake       = 1'b1;
              bytesLeftNxt = bytesLeft - CNT_W'(1);
              timerNxt     = TW'(GAP_CYC - 1);
              stateNxt     = ST_GAP;
            end else begin
              timerNxt = TW'(TRAIL_CYC - 1);
              stateNxt = ST_TRAIL;
            end
          end
        end
      end
      ST_TRAIL: begin
        if (expired) begin
          stb.relNss = 1'b1;
          timerNxt   = TW'(REST_CYC - 1);
          stateNxt   = ST_REST;
        end
      end
      ST_REST: begin
        if (expired) begin
          done     = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      bytesLeft <= '0;
    end else begin
      state     <= stateNxt;
      timer     <= timerNxt;
      bytesLeft <= bytesLeftNxt;
    end
  end

endmodule

// File: rtl/spi_guard_dp.sv
module spi_guard_dp
  import spi_guard_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              miso,
  output logic              lastBit,
  output logic [BYTE_W-1:0] rdData,
  output logic              sck,
  output logic              mosi,
  output logic              nss
);

  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BIT_W-1:0]  bitIdx;

  assign lastBit = (bitIdx == BIT_W'(BYTE_W - 1));
  assign mosi    = txShift[BYTE_W-1];
  assign rdData  = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      bitIdx  <= '0;
      sck     <= 1'b0;
      nss     <= 1'b1;
    end else begin
      if (stb.start) begin
        nss     <= 1'b0;
        txShift <= opcode;
        bitIdx  <= '0;
      end
      if (stb.rise) begin
        sck     <= 1'b1;
        rxShift <= {rxShift[BYTE_W-2:0], miso};
      end
      if (stb.fall) begin
        sck <= 1'b0;
        if (stb.loadNext) begin
          txShift <= wrData;
          bitIdx  <= '0;
        end else begin
          txShift <= {txShift[BYTE_W-2:0], 1'b0};
          bitIdx  <= bitIdx + BIT_W'(1);
        end
      end
      if (stb.relNss) nss <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_guard_host.sv
module spi_guard_host
  import spi_guard_pkg::*;
#(
  parameter int HALF_CYC  = 64,
  parameter int LEAD_CYC  = 1040,
  parameter int GAP_CYC   = 640,
  parameter int TRAIL_CYC = 1600,
  parameter int REST_CYC  = 800,
  parameter int MAX_BYTES = 16,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [7:0]       reqOpcode,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [7:0]       wrData,
  output logic             wrTake,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             done,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             nss
);

  dpStrobe_t stb;
  logic      lastBit;

  spi_guard_ctrl #(
    .HALF_CYC (HALF_CYC),
    .LEAD_CYC (LEAD_CYC),
    .GAP_CYC  (GAP_CYC),
    .TRAIL_CYC(TRAIL_CYC),
    .REST_CYC (REST_CYC),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqCount(reqCount),
    .lastBit (lastBit),
    .stb     (stb),
    .reqReady(reqReady),
    .wrTake  (wrTake),
    .rdValid (rdValid),
    .done    (done)
  );

  spi_guard_dp #(.BYTE_W(8)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opcode (reqOpcode),
    .wrData (wrData),
    .miso   (miso),
    .lastBit(lastBit),
    .rdData (rdData),
    .sck    (sck),
    .mosi   (mosi),
    .nss    (nss)
  );

endmodule

// File: rtl/spi_guard_checker.sv
module spi_guard_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic wrTake,
  input logic rdValid,
  input logic done,
  input logic sck,
  input logic mosi,
  input logic nss
);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!nss && !reqReady));

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    nss |-> !sck);

  assert_take_inside_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (!nss && sck));

  assert_byte_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !sck);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (reqReady && nss));

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rstN)
    (nss && !reqReady) |=> nss);

  assert_mosi_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

bind spi_guard_host spi_guard_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .wrTake  (wrTake),
  .rdValid (rdValid),
  .done    (done),
  .sck     (sck),
  .mosi    (mosi),
  .nss     (nss)
);

// File: tb/sim_spi_guard_host.sv
module sim_spi_guard_host;

  localparam int HALF  = 3;
  localparam int LEAD  = 7;
  localparam int GAP   = 5;
  localparam int TRAIL = 9;
  localparam int REST  = 4;
  localparam int MAXB  = 16;
  localparam int CW    = $clog2(MAXB + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [7:0]    reqOpcode = '0;
  logic [CW-1:0] reqCount = '0;
  logic [7:0]    wrData;
  logic          wrTake, rdValid, done, sck, mosi, miso, nss;
  logic [7:0]    rdData;

  always #2 clk = ~clk;

  spi_guard_host #(
    .HALF_CYC(HALF), .LEAD_CYC(LEAD), .GAP_CYC(GAP),
    .TRAIL_CYC(TRAIL), .REST_CYC(REST), .MAX_BYTES(MAXB)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOpcode(reqOpcode), .reqCount(reqCount), .wrData(wrData),
    .wrTake(wrTake), .rdValid(rdValid), .rdData(rdData), .done(done),
    .sck(sck), .mosi(mosi), .miso(miso), .nss(nss)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Stimulus memories and scoreboard queues
  logic [7:0] txData  [MAXB];
  logic [7:0] respMem [MAXB + 1];
  logic [7:0] expMosi [$];
  logic [7:0] expRd   [$];

  int cyc = 0;
  int takeCnt = 0;
  int takeBase = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wrTake) takeCnt <= takeCnt + 1;
  end
  assign wrData = txData[(takeCnt - takeBase) % MAXB];

  // Peripheral model: returns respMem bits, captures mosi
  int   slvBits = 0;
  logic [7:0] slvIn = '0;
  always @(posedge sck or negedge nss) begin
    if (!sck) begin
      slvBits = 0;
    end else begin
      slvIn = {slvIn[6:0], mosi};
      slvBits++;
      if (slvBits % 8 == 0) begin
        if (expMosi.size() == 0) check(1'b0, "R5 unexpected mosi byte", slvIn, 0);
        else begin
          logic [7:0] e;
          e = expMosi.pop_front();
          check(slvIn == e, "R5 mosi byte", slvIn, e);
        end
      end
    end
  end
  assign miso = (slvBits / 8 <= MAXB) ? respMem[slvBits / 8][7 - (slvBits % 8)] : 1'b0;

  // Monitor: read stream and interval measurement
  logic prevNss = 1'b1, prevSck = 1'b0;
  int tNssFall = 0, tRise = 0, tFall = 0, tNssRise = 0, rises = 0;
  int rdCnt = 0, doneCnt = 0, nssFalls = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevNss && !nss) begin
        tNssFall = cyc; rises = 0; nssFalls++;
      end
      if (!prevSck && sck) begin
        if (rises == 0)          check(cyc - tNssFall == LEAD, "R3 lead", cyc - tNssFall, LEAD);
        else if (rises % 8 == 0) check(cyc - tFall == GAP, "R7 gap", cyc - tFall, GAP);
        else                     check(cyc - tFall == HALF, "R4 low", cyc - tFall, HALF);
        rises++; tRise = cyc;
      end
      if (prevSck && !sck) begin
        check(cyc - tRise == HALF, "R4 high", cyc - tRise, HALF);
        tFall = cyc;
      end
      if (!prevNss && nss) begin
        check(cyc - tFall == TRAIL, "R8 trail", cyc - tFall, TRAIL);
        tNssRise = cyc;
      end
      if (done) begin
        check(cyc == tNssRise + REST - 1, "R9 done timing", cyc - tNssRise, REST - 1);
        doneCnt++;
      end
      if (rdValid) begin
        rdCnt++;
        if (expRd.size() == 0) check(1'b0, "R6 unexpected read byte", rdData, 0);
        else begin
          logic [7:0] e;
          e = expRd.pop_front();
          check(rdData == e, "R6 read byte", rdData, e);
        end
      end
      prevNss = nss;
      prevSck = sck;
    end
  end

  // Driver: pushes expectations and issues one request
  task automatic runTxn(input logic [7:0] op, input int n, input logic [7:0] seed, input bit spam);
    int rd0, take0, done0;
    for (int i = 0; i < MAXB; i++) txData[i] = seed ^ 8'(i * 37);
    for (int i = 0; i <= MAXB; i++) respMem[i] = ~seed + 8'(i * 29);
    if (n == 1) txData[0] = 8'h80;
    if (n == 3) begin txData[0] = 8'h01; respMem[1] = 8'hFF; respMem[2] = 8'h00; end
    expMosi.push_back(op);
    for (int i = 0; i < n; i++) expMosi.push_back(txData[i]);
    for (int i = 0; i <= n; i++) expRd.push_back(respMem[i]);
    while (!reqReady) @(negedge clk);
    rd0 = rdCnt; take0 = takeCnt; done0 = doneCnt;
    takeBase = takeCnt;
    reqOpcode = op; reqCount = CW'(n); reqValid = 1'b1;
    @(negedge clk);
    check(!nss && !reqReady, "R2 accepted", {30'b0, nss, reqReady}, 0);
    if (spam) begin
      reqOpcode = 8'hEE; reqCount = CW'(5);
      for (int k = 0; k < 20; k++) @(negedge clk);
      check(!reqReady, "R11 still busy", reqReady, 0);
    end
    reqValid = 1'b0;
    while (doneCnt == done0) @(negedge clk);
    @(negedge clk);
    check(reqReady, "R9 ready after done", reqReady, 1);
    if (n == 0) check(takeCnt - take0 == 0, "R10 no take", takeCnt - take0, 0);
    else        check(takeCnt - take0 == n, "R5 take count", takeCnt - take0, n);
    check(rdCnt - rd0 == n + 1, n == 0 ? "R10 read count" : "R6 read count", rdCnt - rd0, n + 1);
    check(expMosi.size() == 0 && expRd.size() == 0, "R5 scoreboard drained",
          expMosi.size() + expRd.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(nss && !sck && reqReady && !rdValid && !wrTake && !done, "R1 reset state",
          {26'b0, nss, sck, reqReady, rdValid, wrTake, done}, 6'b101000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runTxn(8'hA5, 0, 8'h5A, 1'b0);   // R10 opcode only
    runTxn(8'h3C, 1, 8'h0F, 1'b0);
    runTxn(8'hC3, 3, 8'hF0, 1'b0);
    runTxn(8'h11, 12, 8'h96, 1'b0);
    runTxn(8'h07, 2, 8'h00, 1'b1);   // R11 requests while busy
    repeat (10) @(negedge clk);
    check(nssFalls == 5, "R11 transaction count", nssFalls, 5);
    check(nss && !sck, "R4 idle after run", {30'b0, nss, sck}, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule